// File: doc/BRIEF.md
# CAN Error-State Change Interrupt Filter

This block sits beside a CAN controller's error-counting logic. It turns the receive and transmit error counters, plus a bus-off indication, into a two-bit error state for each direction. It reports both states to software through status fields. It raises one shared status-change flag when a state transition passes that direction's programmed sensitivity level. Software can choose, separately for each direction, to ignore all transitions or to react only to bus-off changes. It can also react to changes into or out of the error-passive and bus-off states, or to every change.

The status fields are frozen while the flag is pending. Software therefore reads the state that caused the interrupt, and not a later one. Writing a one to the flag bit clears it, and the status fields then catch up on the next clock. An enable register holds the interrupt enables and the two sensitivity fields. While the controller's initialization handshake is active, the enables are forced to zero and writes are refused. The sensitivity fields keep their values. A wake-up enable gates an external wake-up event onto its own request line.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `can_sc_irq`

## Requirements
- R1: Each direction's state uses the encoding 00 OK (counter below 96), 01 warning (96 to 127), 10 error-passive (128 to 255) and 11 bus-off. When bus_off is high, both the transmit state and the receive state read 11.
- R2: Receive sensitivity, at bits 3:2 of the enable register (address 0): 00 means no receive change sets the flag. 01 means only changes where the old or new state is bus-off set it. 10 means only changes where the old or new state is error-passive or bus-off set it. 11 means any change sets it.
- R3: Transmit sensitivity, at bits 5:4 of the enable register, applies the same four levels to transmit state changes.
- R4: A state change that does not match its direction's sensitivity leaves the flag unchanged.
- R5: A qualifying change sets sc_flag at the next clock edge. Writing a 1 to bit 0 of address 1 clears it. If a qualifying change and a clear arrive in the same cycle, the flag stays set.
- R6: rx_stat and tx_stat (also readable at bits 3:2 and 5:4 of address 1) take the current states at every edge where sc_flag is low, and hold while it is high. After a clear, they resample at the edge following the one that cleared the flag.
- R7: sc_irq is high exactly when sc_flag is set and bit 0 of the enable register is set. wake_irq is high exactly when wake_evt is high and bit 1 of the enable register is set.
- R8: While init_req and init_ack are both high, enable bits 1:0 are held at zero. Writes to address 0 take effect only when both init_req and init_ack are low.
- R9: The sensitivity fields keep their programmed values through initialization mode.
- R10: After reset, every register bit reads zero. Bit 1 of address 1 always reads zero, and writes to bits 5:1 of address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_err_cnt | input | 8 | Receive error counter |
| tx_err_cnt | input | 8 | Transmit error counter |
| bus_off | input | 1 | Controller is bus-off |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| wake_evt | input | 1 | Wake-up event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 enable, 1 status/flag) |
| wr_data | input | 6 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 6 | Read data (combinational) |
| rx_stat | output | 2 | Reported receive state |
| tx_stat | output | 2 | Reported transmit state |
| sc_flag | output | 1 | Status-change flag |
| sc_irq | output | 1 | Status-change interrupt request |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
A counter change driven before a rising edge shows up in sc_flag and the status fields right after that edge. Register writes take effect at the edge that samples the strobe. Reads, sc_irq and wake_irq follow their inputs within the same cycle. After a clearing write, the flag is low one edge later, and the status fields move one edge after that. The bench drives inputs on falling edges and samples on the falling edge that follows the exact edge at which each result is due. This lets it check both the held value and the resampled value of the status fields on consecutive cycles.

// File: rtl/can_sc_pkg.sv
package can_sc_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_WARN    = 2'b01,
    ST_PASSIVE = 2'b10,
    ST_BUSOFF  = 2'b11
  } err_st_e;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_RX   = 0;
  localparam int SIDE_TX   = 1;

  // sensitivity codes
  localparam logic [1:0] SENS_NONE    = 2'b00;
  localparam logic [1:0] SENS_BUSOFF  = 2'b01;
  localparam logic [1:0] SENS_PASSIVE = 2'b10;
  localparam logic [1:0] SENS_ALL     = 2'b11;
endpackage

// File: rtl/can_sc_level.sv
module can_sc_level
  import can_sc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             force_off,
  output err_st_e          st
);
  localparam logic [CNT_W-1:0] WARN_T    = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASSIVE_T = CNT_W'(PASSIVE_LIM);

  always_comb begin
    if (force_off)             st = ST_BUSOFF;
    else if (cnt >= PASSIVE_T) st = ST_PASSIVE;
    else if (cnt >= WARN_T)    st = ST_WARN;
    else                       st = ST_OK;
  end
endmodule

// File: rtl/can_sc_filter.sv
module can_sc_filter
  import can_sc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  err_st_e    cur,
  input  logic [1:0] level,
  output logic       hit
);
  err_st_e prev_q;
  logic    changed;
  logic    touches_off;
  logic    touches_passive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= ST_OK;
    else        prev_q <= cur;
  end

  assign changed         = (cur != prev_q);
  assign touches_off     = (cur == ST_BUSOFF) || (prev_q == ST_BUSOFF);
  assign touches_passive = (cur[1] == 1'b1) || (prev_q[1] == 1'b1);

  always_comb begin
    unique case (level)
      SENS_NONE:    hit = 1'b0;
      SENS_BUSOFF:  hit = changed && touches_off;
      SENS_PASSIVE: hit = changed && touches_passive;
      default:      hit = changed;
    endcase
  end
endmodule

// File: rtl/can_sc_regs.sv
module can_sc_regs #(
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             sc_en,
  output logic             wake_en,
  output logic [1:0]       rx_sens,
  output logic [1:0]       tx_sens
);
  logic in_init;
  logic wr_ok;

  assign in_init = init_req && init_ack;
  assign wr_ok   = wr_en && wr_sel && !init_req && !init_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_en   <= 1'b0;
      wake_en <= 1'b0;
      rx_sens <= 2'b00;
      tx_sens <= 2'b00;
    end else if (in_init) begin
      sc_en   <= 1'b0;
      wake_en <= 1'b0;
    end else if (wr_ok) begin
      sc_en   <= wr_data[0];
      wake_en <= wr_data[1];
      rx_sens <= wr_data[3:2];
      tx_sens <= wr_data[5:4];
    end
  end

  AST_INIT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (!sc_en && !wake_en)); // R8
  AST_HALF_INIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req != init_ack) |=> ($stable(sc_en) && $stable(wake_en))); // R8
  AST_SENS_KEPT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> ($stable(rx_sens) && $stable(tx_sens))); // R9
endmodule

// File: rtl/can_sc_irq.sv
module can_sc_irq
  import can_sc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int REG_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic             bus_off,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             wake_evt,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic [1:0]       rx_stat,
  output logic [1:0]       tx_stat,
  output logic             sc_flag,
  output logic             sc_irq,
  output logic             wake_irq
);
  localparam logic ADDR_EN   = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  logic             sc_en;
  logic             wake_en;
  logic [1:0]       rx_sens;
  logic [1:0]       tx_sens;
  logic [CNT_W-1:0] cnt_arr  [NUM_SIDES];
  logic [1:0]       sens_arr [NUM_SIDES];
  err_st_e          st_cur   [NUM_SIDES];
  logic [1:0]       stat_q   [NUM_SIDES];
  logic [NUM_SIDES-1:0] hit;
  logic             any_hit;
  logic             flag_clr;

  assign cnt_arr[SIDE_RX]  = rx_err_cnt;
  assign cnt_arr[SIDE_TX]  = tx_err_cnt;
  assign sens_arr[SIDE_RX] = rx_sens;
  assign sens_arr[SIDE_TX] = tx_sens;

  can_sc_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .init_ack (init_ack),
    .wr_en    (wr_en),
    .wr_sel   (wr_addr == ADDR_EN),
    .wr_data  (wr_data),
    .sc_en    (sc_en),
    .wake_en  (wake_en),
    .rx_sens  (rx_sens),
    .tx_sens  (tx_sens)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    can_sc_level #(
      .CNT_W       (CNT_W),
      .WARN_LIM    (WARN_LIM),
      .PASSIVE_LIM (PASSIVE_LIM)
    ) u_level (
      .cnt       (cnt_arr[s]),
      .force_off (bus_off),
      .st        (st_cur[s])
    );

    can_sc_filter u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (st_cur[s]),
      .level (sens_arr[s]),
      .hit   (hit[s])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat_q[s] <= 2'b00;
      else if (!sc_flag) stat_q[s] <= st_cur[s];
    end
  end

  assign any_hit  = |hit;
  assign flag_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sc_flag <= 1'b0;
    else if (any_hit)  sc_flag <= 1'b1;
    else if (flag_clr) sc_flag <= 1'b0;
  end

  assign rx_stat  = stat_q[SIDE_RX];
  assign tx_stat  = stat_q[SIDE_TX];
  assign sc_irq   = sc_flag && sc_en;
  assign wake_irq = wake_evt && wake_en;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_EN) begin
      rd_data[0]   = sc_en;
      rd_data[1]   = wake_en;
      rd_data[3:2] = rx_sens;
      rd_data[5:4] = tx_sens;
    end else begin
      rd_data[0]   = sc_flag;
      rd_data[3:2] = stat_q[SIDE_RX];
      rd_data[5:4] = stat_q[SIDE_TX];
    end
  end

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> sc_flag); // R5
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_flag && !any_hit) |=> !sc_flag); // R4
  AST_STAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    sc_flag |=> ($stable(rx_stat) && $stable(tx_stat))); // R6
endmodule

// File: tb/sim_can_sc_irq.sv
module sim_can_sc_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_err_cnt = '0;
  logic [7:0] tx_err_cnt = '0;
  logic       bus_off = 1'b0;
  logic       init_req = 1'b0;
  logic       init_ack = 1'b0;
  logic       wake_evt = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [5:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [5:0] rd_data;
  logic [1:0] rx_stat;
  logic [1:0] tx_stat;
  logic       sc_flag;
  logic       sc_irq;
  logic       wake_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  can_sc_irq u0 (
    .clk(clk), .rst_n(rst_n), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .bus_off(bus_off), .init_req(init_req), .init_ack(init_ack),
    .wake_evt(wake_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_stat(rx_stat), .tx_stat(tx_stat),
    .sc_flag(sc_flag), .sc_irq(sc_irq), .wake_irq(wake_irq)
  );

  typedef struct packed {
    logic [7:0] rx0; logic [7:0] tx0; logic bo0;
    logic [7:0] rx1; logic [7:0] tx1; logic bo1;
    logic [1:0] rs;  logic [1:0] ts;  logic flag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{8'd0,   8'd0,   1'b0, 8'd100, 8'd0,   1'b0, 2'd3, 2'd0, 1'b1}, // R2 all
    '{8'd0,   8'd0,   1'b0, 8'd100, 8'd0,   1'b0, 2'd2, 2'd0, 1'b0}, // R4
    '{8'd100, 8'd0,   1'b0, 8'd130, 8'd0,   1'b0, 2'd2, 2'd0, 1'b1}, // R2 passive
    '{8'd100, 8'd0,   1'b0, 8'd130, 8'd0,   1'b0, 2'd1, 2'd0, 1'b0}, // R4
    '{8'd0,   8'd200, 1'b0, 8'd0,   8'd200, 1'b1, 2'd0, 2'd1, 1'b1}, // R3 busoff
    '{8'd0,   8'd0,   1'b0, 8'd0,   8'd100, 1'b0, 2'd0, 2'd3, 1'b1}, // R3 all
    '{8'd0,   8'd100, 1'b0, 8'd0,   8'd130, 1'b0, 2'd0, 2'd1, 1'b0}, // R4
    '{8'd0,   8'd130, 1'b0, 8'd0,   8'd100, 1'b0, 2'd0, 2'd2, 1'b1}, // R3 leave passive
    '{8'd0,   8'd200, 1'b1, 8'd0,   8'd200, 1'b0, 2'd1, 2'd0, 1'b1}, // R2 leave busoff
    '{8'd130, 8'd0,   1'b0, 8'd140, 8'd0,   1'b0, 2'd3, 2'd3, 1'b0}, // R4 no change
    '{8'd0,   8'd200, 1'b1, 8'd0,   8'd200, 1'b0, 2'd0, 2'd2, 1'b1}, // R3 busoff->passive
    '{8'd0,   8'd0,   1'b0, 8'd0,   8'd100, 1'b0, 2'd0, 2'd2, 1'b0}  // R4
  };

  function automatic logic [1:0] exp_st(input logic [7:0] c, input logic off);
    if (off)           return 2'b11;
    else if (c >= 128) return 2'b10;
    else if (c >= 96)  return 2'b01;
    else               return 2'b00;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [5:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(1'b0, d); chk("R10 enable reset", int'(d), 0);
    rd(1'b1, d); chk("R10 status reset", int'(d), 0);
    chk("R7 irq reset", int'({sc_irq, wake_irq}), 0);

    // vector table: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      wr(1'b0, 6'h00);
      @(negedge clk);
      rx_err_cnt = v.rx0; tx_err_cnt = v.tx0; bus_off = v.bo0;
      repeat (2) @(negedge clk);
      wr(1'b1, 6'h01);
      wr(1'b0, {v.ts, v.rs, 2'b00});
      chk("R5 flag clear before vector", int'(sc_flag), 0);
      rx_err_cnt = v.rx1; tx_err_cnt = v.tx1; bus_off = v.bo1;
      @(negedge clk);
      chk(v.ts != 0 ? "R3 flag" : "R2 flag", int'(sc_flag), int'(v.flag));
      chk("R1 rx_stat", int'(rx_stat), int'(exp_st(v.rx1, v.bo1)));
      chk("R1 tx_stat", int'(tx_stat), int'(exp_st(v.tx1, v.bo1)));
    end
    bus_off = 1'b0; rx_err_cnt = 0; tx_err_cnt = 0;
    wr(1'b0, 6'h00);
    repeat (2) @(negedge clk);
    wr(1'b1, 6'h01);
    @(negedge clk);

    // R10 status register writes beyond bit 0 ignored, bit 1 reads 0
    wr(1'b1, 6'h3E);
    rd(1'b1, d); chk("R10 status bits not writable", int'(d), 0);

    // R7 wake gating
    wr(1'b0, 6'h02);
    wake_evt = 1'b1; #0.5;
    chk("R7 wake_irq enabled", int'(wake_irq), 1);
    wr(1'b0, 6'h00);
    #0.5;
    chk("R7 wake_irq disabled", int'(wake_irq), 0);
    wake_evt = 1'b0;

    // R8 R9 initialization mode
    wr(1'b0, 6'h3F);
    rd(1'b0, d); chk("R10 enable readback", int'(d), 'h3F);
    init_req = 1'b1; init_ack = 1'b1;
    @(negedge clk);
    rd(1'b0, d); chk("R8 R9 init clears enables keeps sens", int'(d), 'h3C);
    wr(1'b0, 6'h00);
    rd(1'b0, d); chk("R9 write blocked in init", int'(d), 'h3C);
    init_ack = 1'b0;
    wr(1'b0, 6'h03);
    rd(1'b0, d); chk("R8 write blocked half handshake", int'(d), 'h3C);
    init_req = 1'b0;
    wr(1'b0, 6'h0D); // sc_en, rx_sens=11, tx_sens=00
    rd(1'b0, d); chk("R8 write accepted after init", int'(d), 'h0D);

    // R6 freeze / resample, R7 sc_irq
    rx_err_cnt = 8'd100;
    @(negedge clk);
    chk("R5 flag set", int'(sc_flag), 1);
    chk("R6 rx_stat at set", int'(rx_stat), 1);
    chk("R7 sc_irq enabled", int'(sc_irq), 1);
    rx_err_cnt = 8'd130;
    repeat (2) @(negedge clk);
    chk("R6 rx_stat frozen", int'(rx_stat), 1);
    rd(1'b1, d); chk("R6 status read frozen", int'(d), 'h05);
    wr(1'b1, 6'h01);
    chk("R5 flag cleared", int'(sc_flag), 0);
    chk("R6 rx_stat not yet resampled", int'(rx_stat), 1);
    @(negedge clk);
    chk("R6 rx_stat resampled", int'(rx_stat), 2);

    // R5 set wins over clear in the same cycle
    rx_err_cnt = 8'd100;
    @(negedge clk);
    chk("R5 flag set again", int'(sc_flag), 1);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 6'h01;
    rx_err_cnt = 8'd0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 set wins over clear", int'(sc_flag), 1);
    chk("R6 rx_stat held on collision", int'(rx_stat), 1);

    // R7 sc_irq masked
    wr(1'b0, 6'h0C);
    chk("R7 sc_irq masked", int'(sc_irq), 0);
    chk("R7 flag still set", int'(sc_flag), 1);

    finish_run();
  end
endmodule